// File: doc/BRIEF.md
# Deferred Clock Ratio Controller

This block takes one reference clock and produces two clock enables from it. The faster one is for the processor side. The slower one is for the peripheral side. Software picks each divide ratio by writing a control register. Each field in that register holds a power-of-two code. Consumers that run at the processor rate, such as a DMA engine, qualify their logic with `sys_ce`. Ordinary peripherals qualify theirs with `per_ce`.

A write does not change the ratios at once. The new value is held as pending while a bus transfer is still in progress. Once the bus reports idle, the ratios switch on the next reference clock edge. At that same edge both divider counters restart, so the first period at the new ratio is a full one.

The peripheral enable is never allowed to run faster than the processor enable. If software asks for a faster peripheral ratio, the peripheral side uses the processor ratio. The readback still shows exactly what software wrote.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: After reset, both stored codes are 0, `rd_data` reads 0, `pending` is 0, and `sys_ce` and `per_ce` are high on every cycle.
- R2: A code n from 0 to 5 selects divide-by-2^n. After a switch edge, the enable goes high for the first time in the 2^n-th cycle, and after that once every 2^n cycles.
- R3: The peripheral divider uses the larger of the two codes. As a result, `per_ce` is never high in a cycle where `sys_ce` is low.
- R4: While `pending` is 1 and `bus_busy` is 1, the applied ratios stay unchanged and `pending` stays 1.
- R5: When `pending` is 1, `bus_busy` is 0 and no valid write is presented, the next edge does three things: it applies the pending codes, clears `pending`, and restarts both dividers.
- R6: A valid write sets `pending` at the next edge. The processor code is `wr_data[2:0]` and the peripheral code is `wr_data[5:3]`. At the same edge, `rd_data` (same layout) takes the written value.
- R7: A valid write while `pending` is 1 replaces the pending value. Only the last value written is applied.
- R8: `rd_data` returns the codes as written, not the clamped peripheral code.
- R9: A write in which either field is 6 or 7 is ignored. It leaves `rd_data`, `pending` and the running ratios unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Write value: [2:0] processor code, [5:3] peripheral code |
| bus_busy | input | 1 | High while a bus transfer is in progress |
| rd_data | output | 6 | Register readback, same layout as `wr_data` |
| pending | output | 1 | A written ratio is waiting to be applied |
| sys_ce | output | 1 | Processor-rate clock enable |
| per_ce | output | 1 | Peripheral-rate clock enable |

## Verification
The bench holds `bus_busy` high across a write for several cycles. A design that applied the ratio early would show a change in the enable pattern, or a dropped `pending`, inside that window.

It measures the first and second enable pulse after every switch. A divider that did not restart would produce a short first period, and a wrong decode would produce a wrong spacing.

It writes a peripheral code faster than the processor code. It expects the processor spacing on `per_ce` while the readback keeps the raw value. A missing clamp, or a readback of the clamped value, would fail here.

Two writes during one busy window check that the last write wins. Writes with a reserved code check that the readback and the pending flag stay put.

// File: rtl/clk_ratio_pkg.sv
// Shared types and helpers for the clock ratio controller.
// Assumes codes are unsigned and that a larger code means a slower clock.
package clk_ratio_pkg;
    localparam int SEL_W    = 3;
    localparam int MAX_CODE = 5;

    typedef logic [SEL_W-1:0] sel_t;

    // Packed so that per occupies the upper field bits and sys the lower ones.
    typedef struct packed {
        sel_t per;
        sel_t sys;
    } ratio_t;

    // True when the code is within the supported range.
    function automatic logic code_ok(sel_t c);
        return (int'(c) <= MAX_CODE);
    endfunction

    // Picks the slower (numerically larger) of two codes.
    function automatic sel_t slower(sel_t a, sel_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/clk_sel_reg.sv
// Control register with deferred apply.
// It accepts valid writes into a readback copy and raises pending.
// It copies the value into the applied codes once the bus is idle.
// Assumes bus_busy is synchronous to clk.
// A valid write in the same cycle as an apply defers that apply by one cycle.
module clk_sel_reg
    import clk_ratio_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  ratio_t wr_val,
    input  logic   bus_busy,
    output ratio_t shadow,
    output logic   pend,
    output sel_t   eff_sys,
    output sel_t   eff_per,
    output logic   apply
);
    logic wr_ok;

    // Decode write acceptance and the apply condition.
    always_comb begin
        wr_ok = wr_en && code_ok(wr_val.sys) && code_ok(wr_val.per);
        apply = pend && !bus_busy && !wr_ok;
    end

    // Readback copy: it holds the last accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow <= '0;
        else if (wr_ok) shadow <= wr_val;
    end

    // Pending flag: it is set by a write and cleared when the value is applied.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (wr_ok) pend <= 1'b1;
        else if (apply) pend <= 1'b0;
    end

    // Applied codes. The peripheral code is clamped so it is never faster than sys.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_sys <= '0;
            eff_per <= '0;
        end else if (apply) begin
            eff_sys <= shadow.sys;
            eff_per <= slower(shadow.per, shadow.sys);
        end
    end
endmodule

// File: rtl/clk_div_ce.sv
// Power-of-two clock enable divider.
// The output is high in the last cycle of each 2^code period.
// restart clears the count, so the first period after a change is a full one.
// Assumes code never exceeds MAX_CODE.
module clk_div_ce #(
    parameter int SEL_W    = 3,
    parameter int MAX_CODE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] code,
    output logic             ce
);
    localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   lim_w;
    logic [CNT_W-1:0] lim;

    // Terminal count is 2^code - 1.
    always_comb begin
        lim_w = ((CNT_W+1)'(1) << code) - (CNT_W+1)'(1);
        lim   = lim_w[CNT_W-1:0];
        ce    = (cnt == lim);
    end

    // Period counter: it wraps at the terminal count and restarts on a ratio switch.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (ce)           cnt <= '0;
        else                   cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/clk_ratio_ctrl.sv
// Top level: the control register plus one divider per clock domain.
// Assumes one reference clock and a synchronous active-low reset.
// The two enables share a restart point, which keeps per_ce aligned with sys_ce.
module clk_ratio_ctrl
    import clk_ratio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2*SEL_W-1:0] wr_data,
    input  logic               bus_busy,
    output logic [2*SEL_W-1:0] rd_data,
    output logic               pending,
    output logic               sys_ce,
    output logic               per_ce
);
    localparam int N_DOM = 2;

    ratio_t shadow;
    sel_t   eff_sys, eff_per;
    logic   apply;
    sel_t   dom_code [N_DOM];
    logic   dom_ce   [N_DOM];

    clk_sel_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_val   (ratio_t'(wr_data)),
        .bus_busy (bus_busy),
        .shadow   (shadow),
        .pend     (pending),
        .eff_sys  (eff_sys),
        .eff_per  (eff_per),
        .apply    (apply)
    );

    // Route the applied codes to the dividers: index 0 is sys, index 1 is per.
    always_comb begin
        dom_code[0] = eff_sys;
        dom_code[1] = eff_per;
    end

    for (genvar g = 0; g < N_DOM; g++) begin : g_div
        clk_div_ce #(.SEL_W(SEL_W), .MAX_CODE(MAX_CODE)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (apply),
            .code    (dom_code[g]),
            .ce      (dom_ce[g])
        );
    end

    // Drive the outputs.
    always_comb begin
        rd_data = shadow;
        sys_ce  = dom_ce[0];
        per_ce  = dom_ce[1];
    end
endmodule

// File: rtl/clk_ratio_ctrl_chk.sv
// Port-level checker for clk_ratio_ctrl, attached with bind.
module clk_ratio_ctrl_chk
    import clk_ratio_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [2*SEL_W-1:0] wr_data,
    input logic               bus_busy,
    input logic [2*SEL_W-1:0] rd_data,
    input logic               pending,
    input logic               sys_ce,
    input logic               per_ce
);
    logic wr_valid, wr_bad;

    // Classify the write presented this cycle.
    always_comb begin
        wr_valid = wr_en && code_ok(wr_data[SEL_W-1:0]) && code_ok(wr_data[2*SEL_W-1:SEL_W]);
        wr_bad   = wr_en && !wr_valid;
    end

    a_r3_per_within_sys: assert property (@(posedge clk) disable iff (!rst_n)
        per_ce |-> sys_ce);

    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pending && bus_busy |=> pending);

    a_r5_apply_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !bus_busy && !wr_en |=> !pending);

    a_r6_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> pending && (rd_data == $past(wr_data)));

    a_r9_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad && !pending |=> !pending && $stable(rd_data));
endmodule

bind clk_ratio_ctrl clk_ratio_ctrl_chk u_chk (.*);

// File: tb/tb_clk_ratio_ctrl.sv
// Directed bench for clk_ratio_ctrl. Each task checks its own scenario.
module tb_clk_ratio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic       bus_busy = 1'b0;
    logic [5:0] rd_data;
    logic       pending, sys_ce, per_ce;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clk_ratio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bus_busy(bus_busy), .rd_data(rd_data), .pending(pending),
        .sys_ce(sys_ce), .per_ce(per_ce)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one write for a single cycle. It returns just after the capturing edge.
    task automatic do_write(input int s, input int p);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {3'(p), 3'(s)};
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // Call just after the switch edge.
    // Finds the first and second pulse of each enable and checks the R3 alignment.
    task automatic measure(input int ds, input int dp, input string tag);
        int s1 = 0, s2 = 0, p1 = 0, p2 = 0;
        for (int i = 1; i <= 70; i++) begin
            @(negedge clk);
            if (i == 1) check({tag, " R5 pending cleared"}, int'(pending), 0);
            if (per_ce && !sys_ce) check({tag, " R3 per_ce without sys_ce"}, 1, 0);
            if (sys_ce) begin
                if (s1 == 0) s1 = i;
                else if (s2 == 0) s2 = i;
            end
            if (per_ce) begin
                if (p1 == 0) p1 = i;
                else if (p2 == 0) p2 = i;
            end
        end
        check({tag, " R2 sys first pulse"}, s1, ds);
        check({tag, " R2 sys second pulse"}, s2, 2*ds);
        check({tag, " R2/R3 per first pulse"}, p1, dp);
        check({tag, " R2/R3 per second pulse"}, p2, 2*dp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 sys_ce after reset", int'(sys_ce), 1);
            check("R1 per_ce after reset", int'(per_ce), 1);
        end
        check("R1 pending after reset", int'(pending), 0);
        check("R1 rd_data after reset", int'(rd_data), 0);
    endtask

    task automatic t_basic();
        do_write(2, 3);
        @(negedge clk);
        check("R6 pending after write", int'(pending), 1);
        check("R6 readback", int'(rd_data), (3 << 3) | 2);
        @(posedge clk);
        #1 measure(4, 8, "basic");
        do_write(0, 5);
        @(posedge clk);
        #1 measure(1, 32, "div32");
    endtask

    task automatic t_clamp();
        do_write(3, 1);
        @(negedge clk);
        check("R8 raw readback", int'(rd_data), (1 << 3) | 3);
        @(posedge clk);
        #1 measure(8, 8, "clamp R3");
        check("R8 readback after apply", int'(rd_data), (1 << 3) | 3);
    endtask

    task automatic t_busy();
        int s_cnt = 0;
        @(negedge clk);
        bus_busy = 1'b1;
        do_write(1, 1);
        // The old ratio (divide by 8) keeps running while the bus is busy.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check("R4 pending held while busy", int'(pending), 1);
            if (sys_ce) s_cnt++;
        end
        check("R4 old sys ratio kept (pulses in 16)", s_cnt, 2);
        bus_busy = 1'b0;
        @(posedge clk);
        #1 measure(2, 2, "busy release R4");
    endtask

    task automatic t_replace();
        @(negedge clk);
        bus_busy = 1'b1;
        do_write(4, 4);
        do_write(0, 2);
        repeat (3) @(negedge clk);
        check("R7 pending held", int'(pending), 1);
        check("R7 readback shows last write", int'(rd_data), (2 << 3) | 0);
        bus_busy = 1'b0;
        @(posedge clk);
        #1 measure(1, 4, "replace R7");
    endtask

    task automatic t_reserved();
        do_write(6, 1);
        @(negedge clk);
        check("R9 readback unchanged (sys=6)", int'(rd_data), (2 << 3) | 0);
        check("R9 pending not set (sys=6)", int'(pending), 0);
        do_write(2, 7);
        @(negedge clk);
        check("R9 readback unchanged (per=7)", int'(rd_data), (2 << 3) | 0);
        check("R9 pending not set (per=7)", int'(pending), 0);
        // The running ratios are still 1 and 4. The counters were not restarted,
        // so only the spacing between pulses is checked.
        begin
            int s_cnt = 0, p_cnt = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (sys_ce) s_cnt++;
                if (per_ce) p_cnt++;
            end
            check("R9 sys ratio unchanged", s_cnt, 16);
            check("R9 per ratio unchanged", p_cnt, 4);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_clamp();
        t_busy();
        t_replace();
        t_reserved();
        done = 1'b1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule